// File: doc/BRIEF.md
# Pipeline Operand Forwarding Selector

This block sits in front of the ALU of a five-stage 32-bit integer pipeline with fixed-field instruction words. It takes three instruction words as they stand in the pipeline: the consumer in the decode/execute latch, the younger producer in the execute/memory latch, and the older producer in the memory/writeback latch. It decodes the register fields of all three words itself, so the pipeline only has to carry instruction words, not separately extracted register numbers.

For each ALU operand it decides where the value must come from. The choices are the register-file read value, the result held at the execute/memory boundary, or the result held at the memory/writeback boundary. It reports the choice as a two-bit select code and also drives the chosen 32-bit value. The block is purely combinational. Register-file writeback, stall generation and branch redirection are left to the surrounding pipeline.

Top module: `operand_forward_sel`

## Requirements
- R1: Select codes are 2'b00 for the register-file value, 2'b01 for `ex_result` and 2'b10 for `mem_result`. Code 2'b11 is never produced. `op_a` and `op_b` always equal the candidate named by `sel_a` and `sel_b`.
- R2: Fields are read from fixed positions: opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and function [5:0]. Operand A is steered by the rs field and operand B by the rt field.
- R3: An R-type consumer whose source equals the rd of an R-type producer in the execute/memory slot selects 2'b01 on that operand.
- R4: A source that matches only the destination of the memory/writeback producer selects 2'b10.
- R5: When both producers write the register a source reads, the execute/memory producer wins and the select is 2'b01.
- R6: Register 0 is never forwarded. A consumer field of 0 always gives 2'b00, and a producer whose destination is 0 is ignored.
- R7: An all-zero instruction word is a no-op. It is never a producer and reads no source.
- R8: Destinations are as follows. Opcode 0x00 writes rd, except function 0x08 (register jump), which writes nothing. Opcodes 0x08 to 0x0F (immediate ALU) and 0x23 (load) write rt. Opcode 0x2B (store), 0x04/0x05 (branches), 0x02/0x03 (jumps) and every other opcode write nothing.
- R9: Sources are as follows. Constant shifts (opcode 0x00 with function 0x00, 0x02 or 0x03) read only rt. Register jumps read only rs. Other opcode-0x00 words read rs and rt. Opcodes 0x08 to 0x0E and 0x23 read only rs. Opcode 0x0F reads nothing. Stores and branches read both. An operand whose field is not read selects 2'b00.
- R10: A constant shift whose rt was written by the immediately preceding add selects 2'b01 on operand B and 2'b00 on operand A, even when its rs field is non-zero.
- R11: Operands A and B are decided independently. One may take 2'b01 while the other takes 2'b10 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ir_idex | input | 32 | Consumer instruction word at the decode/execute boundary |
| ir_exmem | input | 32 | Younger producer instruction word at the execute/memory boundary |
| ir_memwb | input | 32 | Older producer instruction word at the memory/writeback boundary |
| rf_a | input | DATA_W | Register-file value read for rs |
| rf_b | input | DATA_W | Register-file value read for rt |
| ex_result | input | DATA_W | Result held at the execute/memory boundary |
| mem_result | input | DATA_W | Result held at the memory/writeback boundary |
| sel_a | output | 2 | Source select for operand A |
| sel_b | output | 2 | Source select for operand B |
| op_a | output | DATA_W | Chosen operand A value |
| op_b | output | DATA_W | Chosen operand B value |

## Verification
The assertions assume that all inputs are known, two-state values whenever they are checked. They also assume that `ex_result` and `mem_result` are the true results of the words in the matching slots. The block cannot detect a load still in the execute/memory slot, so its checks rely on a stall unit outside the block to keep any dependent consumer away from that case. The stimulus drives every input at once with defined values, then samples only after the inputs have settled. It never places a dependent consumer behind a load in the younger slot.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int IW = 32;
    localparam int RW = 5;

    // R2: field positions
    localparam int OP_HI = 31;
    localparam int OP_LO = 26;
    localparam int RS_HI = 25;
    localparam int RS_LO = 21;
    localparam int RT_HI = 20;
    localparam int RT_LO = 16;
    localparam int RD_HI = 15;
    localparam int RD_LO = 11;
    localparam int FN_HI = 5;
    localparam int FN_LO = 0;

    localparam logic [5:0] OPC_SPECIAL = 6'h00;
    localparam logic [5:0] OPC_BEQ     = 6'h04;
    localparam logic [5:0] OPC_BNE     = 6'h05;
    localparam logic [5:0] OPC_IMM_LO  = 6'h08;
    localparam logic [5:0] OPC_IMM_HI  = 6'h0E;
    localparam logic [5:0] OPC_LUI     = 6'h0F;
    localparam logic [5:0] OPC_LOAD    = 6'h23;
    localparam logic [5:0] OPC_STORE   = 6'h2B;

    localparam logic [5:0] FN_SHL_K  = 6'h00;
    localparam logic [5:0] FN_SHR_K  = 6'h02;
    localparam logic [5:0] FN_SHA_K  = 6'h03;
    localparam logic [5:0] FN_JUMP_R = 6'h08;

    // R1: select encoding
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_EX  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;

    typedef enum logic [3:0] {
        CLS_NONE,
        CLS_REG3,
        CLS_SHIFT_K,
        CLS_JUMP_R,
        CLS_IMM_ALU,
        CLS_LUI,
        CLS_LOAD,
        CLS_STORE,
        CLS_BRANCH
    } instr_cls_e;

    typedef struct packed {
        logic          use_rs;
        logic          use_rt;
        logic [RW-1:0] rs;
        logic [RW-1:0] rt;
    } src_use_t;

    typedef struct packed {
        logic          wr;
        logic [RW-1:0] rd;
    } dst_t;

    typedef struct packed {
        logic          used;
        logic [RW-1:0] idx;
    } lane_req_t;

    function automatic instr_cls_e classify(input logic [IW-1:0] ir);
        instr_cls_e c;
        logic [5:0] opc;
        logic [5:0] fn;
        opc = ir[OP_HI:OP_LO];
        fn  = ir[FN_HI:FN_LO];
        c   = CLS_NONE;
        if (ir == '0) begin
            c = CLS_NONE;                      // R7: no-op
        end else begin
            case (opc) inside
                OPC_SPECIAL: begin
                    if (fn == FN_SHL_K || fn == FN_SHR_K || fn == FN_SHA_K)
                        c = CLS_SHIFT_K;
                    else if (fn == FN_JUMP_R)
                        c = CLS_JUMP_R;
                    else
                        c = CLS_REG3;
                end
                [OPC_IMM_LO:OPC_IMM_HI]: c = CLS_IMM_ALU;
                OPC_LUI:                 c = CLS_LUI;
                OPC_LOAD:                c = CLS_LOAD;
                OPC_STORE:               c = CLS_STORE;
                OPC_BEQ, OPC_BNE:        c = CLS_BRANCH;
                default:                 c = CLS_NONE;
            endcase
        end
        return c;
    endfunction

    // R9: which fields a word reads
    function automatic src_use_t sources_of(input instr_cls_e c,
                                            input logic [IW-1:0] ir);
        src_use_t s;
        s.rs = ir[RS_HI:RS_LO];
        s.rt = ir[RT_HI:RT_LO];
        unique case (c)
            CLS_REG3, CLS_STORE, CLS_BRANCH: begin
                s.use_rs = 1'b1; s.use_rt = 1'b1;
            end
            CLS_SHIFT_K: begin
                s.use_rs = 1'b0; s.use_rt = 1'b1;
            end
            CLS_JUMP_R, CLS_IMM_ALU, CLS_LOAD: begin
                s.use_rs = 1'b1; s.use_rt = 1'b0;
            end
            default: begin
                s.use_rs = 1'b0; s.use_rt = 1'b0;
            end
        endcase
        return s;
    endfunction

    // R8: which register a word writes
    function automatic dst_t dest_of(input instr_cls_e c,
                                     input logic [IW-1:0] ir);
        dst_t d;
        unique case (c)
            CLS_REG3, CLS_SHIFT_K: begin
                d.wr = 1'b1; d.rd = ir[RD_HI:RD_LO];
            end
            CLS_IMM_ALU, CLS_LUI, CLS_LOAD: begin
                d.wr = 1'b1; d.rd = ir[RT_HI:RT_LO];
            end
            default: begin
                d.wr = 1'b0; d.rd = '0;
            end
        endcase
        return d;
    endfunction

    // R6: register 0 never matches
    function automatic logic hits(input lane_req_t q, input dst_t d);
        return q.used && d.wr && (d.rd != '0) && (d.rd == q.idx);
    endfunction

endpackage

// File: rtl/fwd_decode.sv
module fwd_decode
    import fwd_pkg::*;
(
    input  logic [IW-1:0] ir,
    output src_use_t      src,
    output dst_t          dst
);
    instr_cls_e cls;

    always_comb begin
        cls = classify(ir);
        src = sources_of(cls, ir);
        dst = dest_of(cls, ir);
    end
endmodule

// File: rtl/fwd_lane.sv
module fwd_lane
    import fwd_pkg::*;
(
    input  lane_req_t req,
    input  dst_t      dst_young,
    input  dst_t      dst_old,
    output fwd_sel_e  sel
);
    logic hit_young;
    logic hit_old;

    always_comb begin
        hit_young = hits(req, dst_young);
        hit_old   = hits(req, dst_old);
        // R5: younger producer has priority
        if (hit_young)
            sel = FWD_EX;
        else if (hit_old)
            sel = FWD_MEM;
        else
            sel = FWD_RF;
    end
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_sel_e          sel,
    input  logic [DATA_W-1:0] from_rf,
    input  logic [DATA_W-1:0] from_ex,
    input  logic [DATA_W-1:0] from_mem,
    output logic [DATA_W-1:0] value
);
    always_comb begin
        unique case (sel)
            FWD_EX:  value = from_ex;
            FWD_MEM: value = from_mem;
            default: value = from_rf;
        endcase
    end
endmodule

// File: rtl/operand_forward_sel.sv
module operand_forward_sel
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [31:0]       ir_idex,
    input  logic [31:0]       ir_exmem,
    input  logic [31:0]       ir_memwb,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic [DATA_W-1:0] ex_result,
    input  logic [DATA_W-1:0] mem_result,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_b
);
    localparam int N_LANE = 2;

    src_use_t cons_src, young_src, old_src;
    dst_t     cons_dst, young_dst, old_dst;

    fwd_decode u_dec_cons  (.ir(ir_idex),  .src(cons_src),  .dst(cons_dst));
    fwd_decode u_dec_young (.ir(ir_exmem), .src(young_src), .dst(young_dst));
    fwd_decode u_dec_old   (.ir(ir_memwb), .src(old_src),   .dst(old_dst));

    // Only the consumer's sources and the producers' destinations matter.
    logic unused_roles;
    assign unused_roles = ^{cons_dst, young_src, old_src};

    lane_req_t         req  [N_LANE];
    fwd_sel_e          lsel [N_LANE];
    logic [DATA_W-1:0] rfv  [N_LANE];
    logic [DATA_W-1:0] outv [N_LANE];

    // R2: lane 0 follows rs, lane 1 follows rt
    assign req[0] = '{used: cons_src.use_rs, idx: cons_src.rs};
    assign req[1] = '{used: cons_src.use_rt, idx: cons_src.rt};
    assign rfv[0] = rf_a;
    assign rfv[1] = rf_b;

    // R11: each lane decides alone
    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        fwd_lane u_lane (
            .req       (req[g]),
            .dst_young (young_dst),
            .dst_old   (old_dst),
            .sel       (lsel[g])
        );
        fwd_opmux #(.DATA_W(DATA_W)) u_mux (
            .sel      (lsel[g]),
            .from_rf  (rfv[g]),
            .from_ex  (ex_result),
            .from_mem (mem_result),
            .value    (outv[g])
        );
    end

    assign sel_a = lsel[0];
    assign sel_b = lsel[1];
    assign op_a  = outv[0];
    assign op_b  = outv[1];
endmodule

// File: rtl/fwd_chk.sv
module fwd_chk #(
    parameter int DATA_W = 32
) (
    input logic [31:0]       ir_idex,
    input logic [31:0]       ir_exmem,
    input logic [31:0]       ir_memwb,
    input logic [DATA_W-1:0] rf_a,
    input logic [DATA_W-1:0] rf_b,
    input logic [DATA_W-1:0] ex_result,
    input logic [DATA_W-1:0] mem_result,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b
);
    logic known;
    assign known = !$isunknown({ir_idex, ir_exmem, ir_memwb, rf_a, rf_b,
                                ex_result, mem_result, sel_a, sel_b, op_a, op_b});

    always_comb begin
        if (known) begin
            a_r1_sel_legal: assert (sel_a != 2'b11 && sel_b != 2'b11);
            if (sel_a == 2'b00) a_r1_opa_rf:  assert (op_a == rf_a);
            if (sel_a == 2'b01) a_r1_opa_ex:  assert (op_a == ex_result);
            if (sel_a == 2'b10) a_r1_opa_mem: assert (op_a == mem_result);
            if (sel_b == 2'b00) a_r1_opb_rf:  assert (op_b == rf_b);
            if (sel_b == 2'b01) a_r1_opb_ex:  assert (op_b == ex_result);
            if (sel_b == 2'b10) a_r1_opb_mem: assert (op_b == mem_result);
            if (ir_idex[25:21] == 5'd0) a_r6_zero_rs: assert (sel_a == 2'b00);
            if (ir_idex[20:16] == 5'd0) a_r6_zero_rt: assert (sel_b == 2'b00);
            if (ir_idex == 32'd0) a_r7_nop_cons: assert (sel_a == 2'b00 && sel_b == 2'b00);
            if (ir_exmem == 32'd0) a_r7_nop_young: assert (sel_a != 2'b01 && sel_b != 2'b01);
            if (ir_memwb == 32'd0) a_r7_nop_old: assert (sel_a != 2'b10 && sel_b != 2'b10);
            if (ir_exmem == ir_memwb) a_r5_young_wins: assert (sel_a != 2'b10 && sel_b != 2'b10);
        end
    end
endmodule

bind operand_forward_sel fwd_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_operand_forward_sel.sv
module tb_operand_forward_sel;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [31:0]   ir_idex, ir_exmem, ir_memwb;
    logic [DW-1:0] rf_a, rf_b, ex_result, mem_result;
    logic [1:0]    sel_a, sel_b;
    logic [DW-1:0] op_a, op_b;

    operand_forward_sel #(.DATA_W(DW)) dut (.*);

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int cycles = 0;

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [4:0] sh,
                                          input logic [5:0] fn);
        return {6'h00, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] add3(input logic [4:0] rs, input logic [4:0] rt,
                                         input logic [4:0] rd);
        return enc_r(rs, rt, rd, 5'd0, 6'h20);
    endfunction

    typedef struct packed {
        logic [31:0] c;
        logic [31:0] y;
        logic [31:0] o;
        logic [1:0]  sa;
        logic [1:0]  sb;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{add3(1,2,3), add3(4,5,1), 32'd0, 2'b01, 2'b00, 8'd3},                       // R3
        '{add3(1,2,3), 32'd0, add3(4,5,2), 2'b00, 2'b10, 8'd4},                       // R4
        '{add3(1,1,3), add3(4,5,1), add3(6,7,1), 2'b01, 2'b01, 8'd5},                 // R5
        '{add3(1,2,3), add3(4,5,2), add3(6,7,1), 2'b10, 2'b01, 8'd11},                // R11
        '{enc_r(0,3,4,2,6'h00), add3(1,2,3), 32'd0, 2'b00, 2'b01, 8'd10},             // R10
        '{add3(0,0,3), add3(1,2,0), add3(1,2,0), 2'b00, 2'b00, 8'd6},                 // R6
        '{add3(5,5,6), enc_i(6'h08,1,5,16'd7), 32'd0, 2'b01, 2'b01, 8'd8},            // R8 imm ALU writes rt
        '{add3(7,8,6), 32'd0, enc_i(6'h23,1,8,16'd0), 2'b00, 2'b10, 8'd8},            // R8 load writes rt
        '{add3(9,1,6), enc_i(6'h2B,1,9,16'h4800), 32'd0, 2'b00, 2'b00, 8'd8},         // R8 store writes none
        '{add3(10,2,6), enc_i(6'h04,1,10,16'h5000), enc_r(1,3,2,0,6'h08), 2'b00, 2'b00, 8'd8}, // R8 branch, jr
        '{add3(11,11,6), {6'h02,5'd0,5'd11,5'd11,11'd0}, {6'h03,5'd0,5'd11,5'd11,11'd0}, 2'b00, 2'b00, 8'd8}, // R8 jumps
        '{add3(12,12,6), {6'h3F,5'd1,5'd12,5'd12,11'd0}, 32'd0, 2'b00, 2'b00, 8'd8},  // R8 unknown opcode
        '{enc_i(6'h08,1,5,16'd0), add3(6,7,5), add3(6,7,1), 2'b10, 2'b00, 8'd9},      // R9 imm reads rs only
        '{enc_i(6'h0F,1,2,16'h1234), add3(3,4,1), add3(3,4,2), 2'b00, 2'b00, 8'd9},   // R9 lui reads none
        '{enc_i(6'h2B,1,2,16'd0), add3(3,4,2), add3(3,4,1), 2'b10, 2'b01, 8'd9},      // R9 store reads both
        '{enc_i(6'h04,3,4,16'd0), add3(1,2,3), 32'd0, 2'b01, 2'b00, 8'd9},            // R9 branch
        '{enc_r(5,0,0,0,6'h08), add3(1,2,5), 32'd0, 2'b01, 2'b00, 8'd9},              // R9 jr
        '{enc_r(1,2,4,3,6'h00), add3(3,4,1), add3(3,4,2), 2'b00, 2'b10, 8'd10},       // R10 rs ignored
        '{enc_r(1,2,4,0,6'h04), add3(3,4,1), add3(3,4,2), 2'b01, 2'b10, 8'd9},        // R9 variable shift
        '{add3(8,9,6), add3(1,2,8), enc_i(6'h23,1,8,16'd0), 2'b01, 2'b00, 8'd5},      // R5 load older
        '{32'd0, add3(1,2,3), add3(1,2,4), 2'b00, 2'b00, 8'd7}                        // R7 nop consumer
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pick(input logic [1:0] s, input logic [DW-1:0] rf);
        return (s == 2'b01) ? ex_result : (s == 2'b10) ? mem_result : rf;
    endfunction

    task automatic apply(input logic [31:0] c, input logic [31:0] y, input logic [31:0] o);
        @(negedge clk);
        ir_idex = c; ir_exmem = y; ir_memwb = o;
        #2;
    endtask

    task automatic check_all(input string req, input logic [1:0] sa, input logic [1:0] sb);
        chk(req, "sel_a", {30'd0, sel_a}, {30'd0, sa});
        chk(req, "sel_b", {30'd0, sel_b}, {30'd0, sb});
        chk("R1", "op_a", op_a, pick(sa, rf_a));
        chk("R1", "op_b", op_b, pick(sb, rf_b));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rf_a = 32'hA1A1_0001; rf_b = 32'hB2B2_0002;
        ex_result = 32'hE3E3_0003; mem_result = 32'hC4C4_0004;

        // Idle pipeline of no-ops: everything from the register file (R7, R1)
        apply(32'd0, 32'd0, 32'd0);
        check_all("R7", 2'b00, 2'b00);

        foreach (VECS[i]) begin
            apply(VECS[i].c, VECS[i].y, VECS[i].o);
            check_all($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].sa, VECS[i].sb);
        end

        // R6: every non-zero register forwards; R5 when both slots write it
        for (int r = 1; r < 32; r++) begin
            apply(add3(r[4:0], r[4:0], 5'd6), add3(5'd1, 5'd2, r[4:0]), add3(5'd1, 5'd2, r[4:0]));
            check_all("R5", 2'b01, 2'b01);
        end

        // R1: operands track new candidate values with selects held
        apply(add3(1,2,3), add3(4,5,2), add3(6,7,1));
        ex_result = 32'h0BAD_F00D; mem_result = 32'h1234_5678;
        rf_a = 32'h0; rf_b = 32'hFFFF_FFFF;
        #2;
        check_all("R1", 2'b10, 2'b01);

        // R2: swapping field positions swaps the lanes
        apply(add3(2,1,3), add3(4,5,2), add3(6,7,1));
        check_all("R2", 2'b01, 2'b10);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule